// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous Static RAM

This block sits between a synchronous request port and an external asynchronous 64K x 16 static RAM. A request is accepted with a valid/ready handshake. It carries a direction flag, a word address, write data and a two-bit lane mask. A read returns the selected byte lanes with a one-cycle valid strobe. On the memory side the block drives active-low select, write, output-enable and per-lane byte strobes, an address bus, and a data bus. The data bus is split into output, output-enable and input so that the pad ring can build the tristate.

Every phase of an access is timed by one down-counter. Its lengths come from nanosecond parameters, rounded up to whole clock periods with a floor of one cycle. A write is controlled by the write strobe. It begins with a guard interval in which the strobe is low but the data bus is not yet driven, so that memory outputs left active by a preceding read have time to turn off. A sleep input parks the memory in deselected standby. Once sleep is released, a recovery interval must pass before the next request is accepted.

Top module: `sram_lane_ctrl`

## Requirements
- R1: In reset and straight after it, every memory strobe (select, write, output enable, both byte strobes) is high, the data bus is not driven, `rsp_valid` is low and `req_ready` is high.
- R2: During a read, select and output enable are low and write is high. The lower byte strobe is low exactly when mask bit 0 is set, and the upper strobe is low exactly when mask bit 1 is set. The address equals the request address and stays stable for the whole access.
- R3: A read holds its strobes for RD cycles, where RD is the larger of the rounded read-cycle and address-access times. `rsp_valid` is high for exactly one cycle, RD+1 cycles after the accepting edge.
- R4: The returned word takes bits 7:0 from the bus when mask bit 0 is set and bits 15:8 when mask bit 1 is set. Lanes that are not selected are returned as zero.
- R5: During a write, output enable is high throughout, select is low, and the byte strobes follow the mask. The write strobe stays low for at least the rounded write-pulse time.
- R6: The write strobe is low for GRD = ceil(20 ns / clock) cycles before data is driven. Data is then driven for WD cycles while the strobe is low, where WD is the largest of the rounded data-setup time, the pulse minus GRD and the write cycle minus GRD. Data stays driven for one more cycle after the strobe rises.
- R7: The data bus is driven only while output enable is high, and never while the memory could still be driving its outputs.
- R8: Whenever the block is ready for a request, select and both byte strobes are high.
- R9: While sleep is high and the block is idle, the memory is deselected and `req_ready` is low. A pending request starts no access.
- R10: After sleep falls, `req_ready` stays low for RCV = ceil(55 ns / clock) cycles before the next request can be accepted.
- R11: A write with an empty mask changes no stored lane, and a read with an empty mask returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| sleep_req | input | 1 | Enter deselected standby |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 16 | Read data, unselected lanes zero |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data from the memory pins |

## Verification
The hardest situation to reach from the ports is a write that follows a read directly, while the memory model still holds its outputs on for the turn-off time. That is the moment when a short guard would make both sides drive the bus. The sweep reads every lane pattern back to back and follows a read with a write to the same word. A memory model with a linger counter flags any overlap. The same model commits a write only when the pulse and data-setup windows measured on its own pins are long enough, so a shortened phase appears as stale data on the following read.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int AW       = 16,
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 55,
  parameter int T_AA_NS  = 55,
  parameter int T_WC_NS  = 55,
  parameter int T_WP_NS  = 45,
  parameter int T_DS_NS  = 25,
  parameter int T_WHZ_NS = 20,
  parameter int T_RCV_NS = 55
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_mask,
  input  logic          sleep_req,
  output logic          rsp_valid,
  output logic [15:0]   rsp_data,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_in
);
  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC  = imax(cyc(T_RC_NS), cyc(T_AA_NS));
  localparam int GRD_CYC = cyc(T_WHZ_NS);
  localparam int WD_CYC  = imax(imax(cyc(T_DS_NS), cyc(T_WP_NS) - GRD_CYC),
                                imax(cyc(T_WC_NS) - GRD_CYC, 1));
  localparam int RCV_CYC = cyc(T_RCV_NS);
  localparam int MAX_CYC = imax(imax(RD_CYC, GRD_CYC), imax(WD_CYC, RCV_CYC));
  localparam int CW      = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_WGRD, S_WDAT, S_WHLD, S_STBY, S_RCV
  } st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [AW-1:0]  addr_q;
  logic [15:0]    wdat_q;
  logic [1:0]     mask_q;
  logic           acc;
  logic           done;

  assign acc        = (st == S_RD) || (st == S_WGRD) || (st == S_WDAT);
  assign done       = (cnt == '0);
  assign req_ready  = (st == S_IDLE) && !sleep_req;
  assign mem_cs_n   = !acc;
  assign mem_lb_n   = !(acc && mask_q[0]);
  assign mem_ub_n   = !(acc && mask_q[1]);
  assign mem_we_n   = !((st == S_WGRD) || (st == S_WDAT));
  assign mem_oe_n   = (st != S_RD);
  assign mem_dq_oe  = (st == S_WDAT) || (st == S_WHLD);
  assign mem_dq_out = wdat_q;
  assign mem_addr   = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      wdat_q    <= '0;
      mask_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (sleep_req) begin
            st <= S_STBY;
          end else if (req_valid) begin
            addr_q <= req_addr;
            wdat_q <= req_wdata;
            mask_q <= req_mask;
            if (req_write) begin
              st  <= S_WGRD;
              cnt <= CW'(GRD_CYC - 1);
            end else begin
              st  <= S_RD;
              cnt <= CW'(RD_CYC - 1);
            end
          end
        end
        S_RD: begin
          if (done) begin
            rsp_data  <= {mask_q[1] ? mem_dq_in[15:8] : 8'h00,
                          mask_q[0] ? mem_dq_in[7:0]  : 8'h00};
            rsp_valid <= 1'b1;
            st        <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        S_WGRD: begin
          if (done) begin
            st  <= S_WDAT;
            cnt <= CW'(WD_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_WDAT: begin
          if (done) st <= S_WHLD;
          else cnt <= cnt - 1'b1;
        end
        S_WHLD: st <= S_IDLE;
        S_STBY: begin
          if (!sleep_req) begin
            st  <= S_RCV;
            cnt <= CW'(RCV_CYC - 1);
          end
        end
        S_RCV: begin
          if (done) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          sleep_req,
  input logic          rsp_valid,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_lb_n,
  input logic          mem_ub_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_dq_oe
);
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  p_rsp_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_oe_high_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  p_data_at_we_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  p_drive_only_oe_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_idle_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_lb_n && mem_ub_n));

  p_no_accept_asleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> !req_ready);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .sleep_req(sleep_req),
  .rsp_valid(rsp_valid), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
  .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;
  localparam int CLK = 10;
  localparam int RD  = 6;
  localparam int GRD = 2;
  localparam int WD  = 4;
  localparam int WP  = 5;
  localparam int DS  = 3;
  localparam int RCV = 6;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, sleep_req = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic [1:0] req_mask = 0;
  logic req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] rsp_data, mem_addr, mem_dq_out, mem_dq_in;

  int checks = 0, fails = 0, contention = 0, viol = 0;

  always #(CLK/2) clk = ~clk;

  sram_lane_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .sleep_req(sleep_req), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  logic [15:0] mdl [0:255];
  int rd_age = 0, linger = 0, wr_age = 0, dq_age = 0;
  logic [15:0] last_d = 0;
  logic last_lb = 1, last_ub = 1;
  logic rd_cond, wr_cond;

  assign rd_cond = !mem_cs_n && mem_we_n && !mem_oe_n && (!mem_lb_n || !mem_ub_n);
  assign wr_cond = !mem_cs_n && !mem_we_n && (!mem_lb_n || !mem_ub_n);
  assign mem_dq_in[7:0]  = (rd_cond && !mem_lb_n) ?
                           ((rd_age >= RD-1) ? mdl[mem_addr[7:0]][7:0] : 8'h5E) : 8'hC3;
  assign mem_dq_in[15:8] = (rd_cond && !mem_ub_n) ?
                           ((rd_age >= RD-1) ? mdl[mem_addr[7:0]][15:8] : 8'h5E) : 8'h3C;

  always @(posedge clk) begin
    rd_age <= rd_cond ? rd_age + 1 : 0;
    linger <= rd_cond ? 2 : (linger > 0 ? linger - 1 : 0);
    dq_age <= mem_dq_oe ? ((mem_dq_out == last_d) ? dq_age + 1 : 1) : 0;
    last_d <= mem_dq_out;
    if (wr_cond) begin
      wr_age  <= wr_age + 1;
      last_lb <= mem_lb_n;
      last_ub <= mem_ub_n;
    end else if (wr_age > 0) begin
      if (wr_age >= WP && dq_age >= DS) begin
        if (!last_lb) mdl[mem_addr[7:0]][7:0]  <= last_d[7:0];
        if (!last_ub) mdl[mem_addr[7:0]][15:8] <= last_d[15:8];
      end else viol <= viol + 1;
      wr_age <= 0;
    end
  end

  always @(negedge clk)
    if (rst_n && mem_dq_oe && (rd_cond || linger != 0)) contention <= contention + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    int welow, dlow, dhold;
    wait_ready();
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 0;
    check({mem_we_n, mem_oe_n, mem_dq_oe, mem_cs_n, mem_lb_n, mem_ub_n} ==
          {1'b0, 1'b1, 1'b0, 1'b0, !m[0], !m[1]}, "R5", "write strobes",
          {mem_we_n, mem_oe_n, mem_dq_oe, mem_cs_n, mem_lb_n, mem_ub_n},
          {1'b0, 1'b1, 1'b0, 1'b0, !m[0], !m[1]});
    welow = 0; dlow = 0; dhold = 0;
    while (!req_ready) begin
      if (!mem_we_n) welow++;
      if (mem_dq_oe && !mem_we_n) dlow++;
      if (mem_dq_oe && mem_we_n) dhold++;
      @(negedge clk);
    end
    check(welow >= WP, "R5", "write pulse cycles", welow, WP);
    check(welow - dlow == GRD && dlow == WD && dhold == 1, "R6", "guard/data/hold",
          {welow[7:0], dlow[7:0], dhold[7:0]}, {8'(GRD + WD), 8'(WD), 8'd1});
  endtask

  task automatic do_read(input logic [15:0] a, input logic [1:0] m, input logic [15:0] exp);
    int k;
    wait_ready();
    req_valid = 1; req_write = 0; req_addr = a; req_mask = m;
    @(negedge clk);
    req_valid = 0;
    check({mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n} ==
          {1'b0, 1'b0, 1'b1, !m[0], !m[1]} && mem_addr == a, "R2", "read strobes",
          {mem_addr, 11'd0, mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n},
          {a, 11'd0, 1'b0, 1'b0, 1'b1, !m[0], !m[1]});
    k = 1;
    while (!rsp_valid && k < 50) begin @(negedge clk); k++; end
    check(k == RD + 1, "R3", "response latency", k, RD + 1);
    check(rsp_data == exp, (m == 0) ? "R11" : "R4", "read data", rsp_data, exp);
  endtask

  function automatic logic [15:0] fa(input int a); return {a[7:0] ^ 8'h5A, a[7:0]}; endfunction
  function automatic logic [15:0] ff(input int a); return 16'(a * 40503 + 4660); endfunction
  function automatic logic [15:0] fg(input int a); return 16'(a * 7919) ^ 16'hB00F; endfunction
  function automatic logic [15:0] lanes(input logic [15:0] w, input logic [1:0] m);
    return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 16'h0;
    repeat (3) @(negedge clk);
    check({mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, rsp_valid} == 7'b1111100,
          "R1", "reset outputs", {mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, rsp_valid},
          7'b1111100);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && mem_cs_n && !mem_dq_oe, "R1", "after reset",
          {req_ready, mem_cs_n, mem_dq_oe}, 3'b110);
    check(mem_cs_n && mem_lb_n && mem_ub_n, "R8", "idle deselect",
          {mem_cs_n, mem_lb_n, mem_ub_n}, 3'b111);

    for (int a = 0; a < 16; a++) do_write(fa(a), ff(a), 2'b11);
    for (int a = 0; a < 16; a++) do_write(fa(a), fg(a), 2'(a % 4));
    for (int a = 0; a < 16; a++) begin
      logic [15:0] w;
      logic [1:0] pm;
      pm = 2'(a % 4);
      w = {pm[1] ? fg(a)[15:8] : ff(a)[15:8], pm[0] ? fg(a)[7:0] : ff(a)[7:0]};
      for (int m = 0; m < 4; m++) do_read(fa(a), 2'(m), lanes(w, 2'(m)));
      do_write(fa(a), ~w, 2'b11);
      do_read(fa(a), 2'b11, ~w);
    end

    wait_ready();
    sleep_req = 1;
    req_valid = 1; req_write = 0; req_addr = fa(3); req_mask = 2'b11;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      check(!req_ready && mem_cs_n && mem_lb_n && mem_ub_n, "R9", "standby deselect",
            {req_ready, mem_cs_n, mem_lb_n, mem_ub_n}, 4'b0111);
      @(negedge clk);
    end
    req_valid = 0;
    sleep_req = 0;
    begin
      int lo;
      lo = 0;
      @(negedge clk);
      while (!req_ready && lo < 50) begin lo++; @(negedge clk); end
      check(lo == RCV, "R10", "recovery lockout cycles", lo, RCV);
    end
    do_read(fa(3), 2'b11, ~{ff(3)[15:8] ^ 8'h0 ^ (fg(3)[15:8] ^ ff(3)[15:8]),
                          fg(3)[7:0]});

    check(contention == 0, "R7", "bus contention events", contention, 0);
    check(viol == 0, "R6", "write timing violations", viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule